// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits between a small CPU core and its interrupt sources. It gathers four maskable hardware request groups and one software trap. From them it gives the CPU a pending indication and, at each instruction boundary, a one-cycle grant that carries the 16-bit vector address of the chosen source. The four hardware groups are an external request, a timer group, a UART group and an SPI group. The external request comes from an active-low pin, and any of eight port pins can be enabled to act as that same pin.

The external request passes through a synchronizer and then sets a request latch. That latch is cleared by a pulse from the CPU early in the service routine. A write-once option bit sets the trigger rule: either falling edges only, or falling edges plus a held low level. The software trap is served whatever the global mask says. It is ordered against the hardware requests that were already pending when the trap instruction was fetched.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the block shows no grant, the vector output holds 16'h3FFE, the pending output is low and the sensitivity option reads 1 (edge plus level).
- R2: With the option at 0 (edge only), a falling edge on `ext_pin_n` raises a request. After an `ext_clr` pulse the request stays cleared while the pin is held low.
- R3: With the option at 1 (edge plus level), an `ext_clr` pulse while the combined external input is still low leaves the request set. Once the input is high, a clear removes the request.
- R4: A port pin whose enable is 1 acts exactly like `ext_pin_n`. A port pin whose enable is 0 has no effect on the pending output.
- R5: Only the first write to the sensitivity option after reset takes effect. Later writes leave `level_mode` unchanged.
- R6: While `gmask` is 1, no hardware request is granted and pending stays low. A request held during the mask is granted at the first boundary after the mask clears.
- R7: A timer, UART or SPI flag whose local enable is 0 raises no request.
- R8: Grants follow a fixed order from highest to lowest: external at 16'h3FFA, timer at 16'h3FF8, UART at 16'h3FF6, SPI at 16'h3FF4.
- R9: Each group ORs its flag/enable pairs. Any single pair raises the group's request: three pairs for timer, five for UART, two for SPI.
- R10: A software trap signalled by `swi_fetch` is granted at vector 16'h3FFC even while `gmask` is 1.
- R11: Hardware requests that are unmasked and pending when `swi_fetch` pulses are granted before the trap. Requests that arrive after the fetch are granted after it.
- R12: A grant appears only in the cycle after a clock edge that sees `insn_end` high. `take` and `vec` change together, one register stage after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 1 | External request pin, active low |
| port_pin_n | input | NPORT | Port pins, active low |
| port_irq_en | input | NPORT | Per-port enable to act as external request |
| sens_wr | input | 1 | Write strobe for the sensitivity option |
| sens_level | input | 1 | Value written: 1 edge plus level, 0 edge only |
| level_mode | output | 1 | Current sensitivity option |
| ext_clr | input | 1 | One-cycle clear of the external request latch |
| tmr_flag | input | NTMR | Timer flags |
| tmr_en | input | NTMR | Timer local enables |
| uart_flag | input | NUART | UART flags |
| uart_en | input | NUART | UART local enables |
| spi_flag | input | NSPI | SPI flags |
| spi_en | input | NSPI | SPI local enables |
| gmask | input | 1 | Global mask, 1 blocks hardware requests |
| swi_fetch | input | 1 | Pulse: software trap instruction fetched |
| insn_end | input | 1 | Pulse: instruction boundary |
| irq_pending | output | 1 | A grant would be made at the next boundary |
| take | output | 1 | One-cycle grant |
| vec | output | 16 | Vector address of the last grant, reset vector after reset |

## Verification
The properties assume that the CPU never pulses `swi_fetch` in the same cycle as `insn_end`. They also assume that a second trap is not fetched while one is still waiting. The stimulus keeps the two strobes in separate cycles and lets each trap be granted before it fetches another one. Pin changes are held for several cycles so that the two-stage synchronizer always sees them. Each expected vector is queued by the driver at the boundary it pulses, and the monitor checks the grant one cycle later.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NHW  = 4;
    localparam int IDXW = $clog2(NHW);

    localparam logic [IDXW-1:0] HW_EXT  = 2'd0;
    localparam logic [IDXW-1:0] HW_TMR  = 2'd1;
    localparam logic [IDXW-1:0] HW_UART = 2'd2;
    localparam logic [IDXW-1:0] HW_SPI  = 2'd3;

    localparam logic [15:0] VEC_RESET = 16'h3FFE;
    localparam logic [15:0] VEC_TRAP  = 16'h3FFC;
    localparam logic [15:0] VEC_EXT   = 16'h3FFA;
    localparam logic [15:0] VEC_TMR   = 16'h3FF8;
    localparam logic [15:0] VEC_UART  = 16'h3FF6;
    localparam logic [15:0] VEC_SPI   = 16'h3FF4;

    // lowest index is the highest priority
    function automatic logic [IDXW-1:0] first_idx(input logic [NHW-1:0] r);
        logic [IDXW-1:0] k;
        k = '0;
        for (int i = NHW - 1; i >= 0; i--) begin
            if (r[i]) k = IDXW'(i);
        end
        return k;
    endfunction

    function automatic logic [15:0] hw_vector(input logic [IDXW-1:0] idx);
        logic [15:0] v;
        case (idx)
            HW_EXT:  v = VEC_EXT;
            HW_TMR:  v = VEC_TMR;
            HW_UART: v = VEC_UART;
            default: v = VEC_SPI;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int         W         = 1,
    parameter int         STAGES    = 2,
    parameter logic       RESET_BIT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{{W{RESET_BIT}}}};
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/irqc_ext_latch.sv
module irqc_ext_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_low,
    input  logic level_mode,
    input  logic clr,
    output logic latched
);
    typedef struct packed {
        logic prev;
        logic hold;
    } lat_st_t;

    lat_st_t st_d, st_q;
    logic    fall;
    logic    set_req;

    always_comb begin
        st_d     = st_q;
        fall     = req_low & ~st_q.prev;
        set_req  = fall | (level_mode & req_low);
        st_d.prev = req_low;
        // a new set wins over the clear: this gives the level re-arm
        if (set_req)  st_d.hold = 1'b1;
        else if (clr) st_d.hold = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched = st_q.hold;
endmodule

// File: rtl/irqc_group.sv
module irqc_group #(
    parameter int N = 3
) (
    input  logic [N-1:0] flag,
    input  logic [N-1:0] en,
    output logic         req
);
    logic [N-1:0] hit;
    for (genvar g = 0; g < N; g++) begin : g_pair
        assign hit[g] = flag[g] & en[g];
    end
    assign req = |hit;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NPORT       = 8,
    parameter int NTMR        = 3,
    parameter int NUART       = 5,
    parameter int NSPI        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin_n,
    input  logic [NPORT-1:0] port_pin_n,
    input  logic [NPORT-1:0] port_irq_en,
    input  logic             sens_wr,
    input  logic             sens_level,
    output logic             level_mode,
    input  logic             ext_clr,
    input  logic [NTMR-1:0]  tmr_flag,
    input  logic [NTMR-1:0]  tmr_en,
    input  logic [NUART-1:0] uart_flag,
    input  logic [NUART-1:0] uart_en,
    input  logic [NSPI-1:0]  spi_flag,
    input  logic [NSPI-1:0]  spi_en,
    input  logic             gmask,
    input  logic             swi_fetch,
    input  logic             insn_end,
    output logic             irq_pending,
    output logic             take,
    output logic [15:0]      vec
);
    localparam int SW = NPORT + 1;

    typedef struct packed {
        logic           level;
        logic           lock;
        logic           swi_pend;
        logic [NHW-1:0] snap;
        logic           take;
        logic [15:0]    vec;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [SW-1:0]  pins_sync;
    logic           ext_low;
    logic           ext_latched;
    logic           tmr_req, uart_req, spi_req;
    logic [NHW-1:0] hw_req;
    logic [NHW-1:0] active;
    logic [NHW-1:0] eligible;
    logic [IDXW-1:0] pick;

    irqc_sync #(.W(SW), .STAGES(SYNC_STAGES), .RESET_BIT(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({port_pin_n, ext_pin_n}),
        .dout  (pins_sync)
    );

    assign ext_low = ~pins_sync[0] | (|(~pins_sync[SW-1:1] & port_irq_en));

    irqc_ext_latch u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_low    (ext_low),
        .level_mode (st_q.level),
        .clr        (ext_clr),
        .latched    (ext_latched)
    );

    irqc_group #(.N(NTMR))  u_tmr  (.flag(tmr_flag),  .en(tmr_en),  .req(tmr_req));
    irqc_group #(.N(NUART)) u_uart (.flag(uart_flag), .en(uart_en), .req(uart_req));
    irqc_group #(.N(NSPI))  u_spi  (.flag(spi_flag),  .en(spi_en),  .req(spi_req));

    always_comb begin
        hw_req           = '0;
        hw_req[HW_EXT]   = ext_latched;
        hw_req[HW_TMR]   = tmr_req;
        hw_req[HW_UART]  = uart_req;
        hw_req[HW_SPI]   = spi_req;
        active           = hw_req & {NHW{~gmask}};
        eligible         = st_q.snap & active;
    end

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        pick      = '0;

        if (sens_wr && !st_q.lock) begin
            st_d.level = sens_level;
            st_d.lock  = 1'b1;
        end

        if (insn_end) begin
            if (|eligible) begin
                pick            = first_idx(eligible);
                st_d.take       = 1'b1;
                st_d.vec        = hw_vector(pick);
                st_d.snap[pick] = 1'b0;
            end else if (st_q.swi_pend) begin
                st_d.take     = 1'b1;
                st_d.vec      = VEC_TRAP;
                st_d.swi_pend = 1'b0;
                st_d.snap     = '0;
            end else if (|active) begin
                pick      = first_idx(active);
                st_d.take = 1'b1;
                st_d.vec  = hw_vector(pick);
            end
        end else if (swi_fetch) begin
            st_d.swi_pend = 1'b1;
            st_d.snap     = active;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.level    <= 1'b1;
            st_q.vec      <= VEC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    logic sens_lock_w;
    logic swi_pend_w;
    assign sens_lock_w = st_q.lock;
    assign swi_pend_w  = st_q.swi_pend;

    assign level_mode  = st_q.level;
    assign irq_pending = (|active) | st_q.swi_pend;
    assign take        = st_q.take;
    assign vec         = st_q.vec;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           take,
    input logic [15:0]    vec,
    input logic           gmask,
    input logic           insn_end,
    input logic           level_mode,
    input logic           sens_lock,
    input logic           swi_pend,
    input logic [NHW-1:0] active
);
    a_r12_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(insn_end));

    a_r6_mask_blocks_hw: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec != VEC_TRAP) |-> $past(!gmask));

    a_r5_option_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (sens_lock && $past(sens_lock)) |-> $stable(level_mode));

    a_r10_trap_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec == VEC_TRAP) |-> $past(swi_pend));

    a_r8_spi_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec == VEC_SPI && !$past(swi_pend)) |-> $past(active[2:0] == 3'b000));

    a_r8_uart_below_ext_tmr: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec == VEC_UART && !$past(swi_pend)) |-> $past(active[1:0] == 2'b00));
endmodule

bind irq_prio_ctrl irqc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .vec        (vec),
    .gmask      (gmask),
    .insn_end   (insn_end),
    .level_mode (level_mode),
    .sens_lock  (sens_lock_w),
    .swi_pend   (swi_pend_w),
    .active     (active)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 8, NTMR = 3, NUART = 5, NSPI = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin_n = 1'b1;
    logic [NPORT-1:0] port_pin_n = '1;
    logic [NPORT-1:0] port_irq_en = '0;
    logic sens_wr = 1'b0, sens_level = 1'b0, ext_clr = 1'b0;
    logic [NTMR-1:0] tmr_flag = '0, tmr_en = '0;
    logic [NUART-1:0] uart_flag = '0, uart_en = '0;
    logic [NSPI-1:0] spi_flag = '0, spi_en = '0;
    logic gmask = 1'b0, swi_fetch = 1'b0, insn_end = 1'b0;
    logic level_mode, irq_pending, take;
    logic [15:0] vec;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .port_pin_n(port_pin_n),
        .port_irq_en(port_irq_en), .sens_wr(sens_wr), .sens_level(sens_level),
        .level_mode(level_mode), .ext_clr(ext_clr), .tmr_flag(tmr_flag), .tmr_en(tmr_en),
        .uart_flag(uart_flag), .uart_en(uart_en), .spi_flag(spi_flag), .spi_en(spi_en),
        .gmask(gmask), .swi_fetch(swi_fetch), .insn_end(insn_end),
        .irq_pending(irq_pending), .take(take), .vec(vec)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(3); rst_n = 1'b1;
        @(negedge clk);
    endtask

    // boundary with an expected grant
    task automatic boundary(input logic [15:0] exp, input string tag);
        @(negedge clk);
        insn_end = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        insn_end = 1'b0;
    endtask

    // boundary with no grant expected
    task automatic boundary_none(input string tag);
        @(negedge clk); insn_end = 1'b1;
        @(negedge clk); insn_end = 1'b0;
        check(take == 1'b0, tag, {15'd0, take}, 16'd0);
    endtask

    task automatic pulse_clr();
        @(negedge clk); ext_clr = 1'b1;
        @(negedge clk); ext_clr = 1'b0;
    endtask

    task automatic write_sens(input logic v);
        @(negedge clk); sens_wr = 1'b1; sens_level = v;
        @(negedge clk); sens_wr = 1'b0;
    endtask

    task automatic pulse_swi();
        @(negedge clk); swi_fetch = 1'b1;
        @(negedge clk); swi_fetch = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && take) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R12 unexpected grant actual=%h expected=none", vec);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(vec == e, t, vec, e);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        wait_cyc(3); rst_n = 1'b1; @(negedge clk);
        // R1
        check(take == 1'b0, "R1 take", {15'd0, take}, 16'd0);
        check(vec == 16'h3FFE, "R1 vec", vec, 16'h3FFE);
        check(irq_pending == 1'b0, "R1 pending", {15'd0, irq_pending}, 16'd0);
        check(level_mode == 1'b1, "R1 level", {15'd0, level_mode}, 16'd1);

        // R3 level mode: clear while low re-arms
        ext_pin_n = 1'b0; wait_cyc(5);
        check(irq_pending, "R3 set", {15'd0, irq_pending}, 16'd1);
        boundary(16'h3FFA, "R3 grant");
        pulse_clr(); wait_cyc(2);
        check(irq_pending, "R3 rearm", {15'd0, irq_pending}, 16'd1);
        ext_pin_n = 1'b1; wait_cyc(5); pulse_clr(); wait_cyc(2);
        check(!irq_pending, "R3 cleared high", {15'd0, irq_pending}, 16'd0);

        // R5 write once
        write_sens(1'b0);
        check(level_mode == 1'b0, "R5 first", {15'd0, level_mode}, 16'd0);
        write_sens(1'b1);
        check(level_mode == 1'b0, "R5 second ignored", {15'd0, level_mode}, 16'd0);

        // R2 edge only
        ext_pin_n = 1'b0; wait_cyc(5);
        check(irq_pending, "R2 edge", {15'd0, irq_pending}, 16'd1);
        pulse_clr(); wait_cyc(3);
        check(!irq_pending, "R2 stays clear", {15'd0, irq_pending}, 16'd0);
        boundary_none("R2 no grant");
        ext_pin_n = 1'b1; wait_cyc(5);

        // R4 ports
        port_irq_en[3] = 1'b1; port_pin_n[3] = 1'b0; wait_cyc(5);
        check(irq_pending, "R4 enabled port", {15'd0, irq_pending}, 16'd1);
        boundary(16'h3FFA, "R4 port vector");
        pulse_clr(); port_pin_n[3] = 1'b1; port_irq_en[3] = 1'b0; wait_cyc(5);
        port_pin_n[5] = 1'b0; wait_cyc(5);
        check(!irq_pending, "R4 disabled port", {15'd0, irq_pending}, 16'd0);
        port_pin_n[5] = 1'b1; wait_cyc(5);

        // R7 local enable
        tmr_flag[1] = 1'b1; wait_cyc(1);
        check(!irq_pending, "R7 no enable", {15'd0, irq_pending}, 16'd0);
        boundary_none("R7 no grant");
        tmr_en[1] = 1'b1; wait_cyc(1);
        check(irq_pending, "R7 enabled", {15'd0, irq_pending}, 16'd1);
        boundary(16'h3FF8, "R7 timer");
        tmr_flag = '0; tmr_en = '0;

        // R9 group OR, single pairs
        uart_flag[4] = 1'b1; uart_en[4] = 1'b1;
        boundary(16'h3FF6, "R9 uart pair4");
        uart_flag = '0; uart_en = '0;
        spi_flag[0] = 1'b1; spi_en[0] = 1'b1;
        boundary(16'h3FF4, "R9 spi pair0");
        spi_flag = '0; spi_en = '0;
        tmr_flag[2] = 1'b1; tmr_en[2] = 1'b1;
        boundary(16'h3FF8, "R9 timer pair2");
        tmr_flag = '0; tmr_en = '0;

        // R8 priority
        ext_pin_n = 1'b0; tmr_flag[0] = 1'b1; tmr_en[0] = 1'b1;
        uart_flag[0] = 1'b1; uart_en[0] = 1'b1; spi_flag[1] = 1'b1; spi_en[1] = 1'b1;
        wait_cyc(5);
        boundary(16'h3FFA, "R8 ext first");
        pulse_clr();
        boundary(16'h3FF8, "R8 timer second");
        tmr_flag = '0;
        boundary(16'h3FF6, "R8 uart third");
        uart_flag = '0;
        boundary(16'h3FF4, "R8 spi last");
        spi_flag = '0; ext_pin_n = 1'b1; wait_cyc(5);

        // R6 mask
        gmask = 1'b1; tmr_flag[0] = 1'b1; wait_cyc(1);
        check(!irq_pending, "R6 masked pending", {15'd0, irq_pending}, 16'd0);
        boundary_none("R6 masked no grant");
        gmask = 1'b0; wait_cyc(1);
        check(irq_pending, "R6 unmasked", {15'd0, irq_pending}, 16'd1);
        boundary(16'h3FF8, "R6 served after unmask");

        // R10 trap ignores mask
        gmask = 1'b1;
        pulse_swi();
        check(irq_pending, "R10 trap pending", {15'd0, irq_pending}, 16'd1);
        boundary(16'h3FFC, "R10 trap vector");
        boundary_none("R10 masked after trap");
        gmask = 1'b0; tmr_flag = '0;

        // R11 trap ordering
        tmr_flag[0] = 1'b1; wait_cyc(1);
        pulse_swi();
        ext_pin_n = 1'b0; wait_cyc(5);
        boundary(16'h3FF8, "R11 earlier timer first");
        tmr_flag = '0;
        boundary(16'h3FFC, "R11 trap next");
        boundary(16'h3FFA, "R11 later ext after");
        pulse_clr(); ext_pin_n = 1'b1; wait_cyc(3);
        boundary_none("R12 idle boundary");

        // R1 again after reset restores option
        do_reset();
        check(level_mode == 1'b1, "R1 level after reset", {15'd0, level_mode}, 16'd1);

        wait_cyc(3);
        check(exp_q.size() == 0, "R12 all grants seen", 16'(exp_q.size()), 16'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule